// File: doc/BRIEF.md
# Dual-Expiry Watchdog Timer

This block is a register-mapped watchdog timer. Software loads a 12-bit period, sets the enable bit, and then must service the timer at regular intervals by writing a clear bit. A slow counting clock is modelled as a tick-enable input `tick_i`. The counter advances by one on every cycle in which `tick_i` is high. One period lasts `(N + 1) * 2^PRESCALE_W` ticks. `PRESCALE_W` defaults to 20 and can be made smaller for short simulations.

The first expiry that software misses raises a level interrupt. If the next expiry also arrives with no service in between, a sticky reset request is raised. That request stays high until the block's own asynchronous reset. Software can also raise the reset request at once by forcing a parity error.

Writes to every register except the service register pass through a staging slot. The slot stands for a crossing into the slow clock domain, so such a write takes effect only after `SYNC_TICKS` ticks. Once the timer is enabled, both the enable and the period are frozen until the block is reset.

Top module: `wdog_dual_expiry`

## Requirements
- R1: After `rst_ni` is deasserted, `irq_o` and `rst_req_o` are low and every register reads zero. The register offsets are: control 0x00, period 0x04, elapsed count 0x08, service 0x0C, parity mode 0x10, parity trigger 0x14. Reads of any other offset return zero.
- R2: Writing 1 to control bit 0 enables counting, and control bit 0 reads back the enable. Once enabled, a later write of 0 does not disable the timer before the next block reset.
- R3: The period N is held in bits [31:20] of the period register. All other bits are dropped on write and read back as zero.
- R4: While enabled, the elapsed count wraps after `(N + 1) * 2^PRESCALE_W` ticks. The first wrap with no pending interrupt sets `irq_o`.
- R5: A wrap that occurs while `irq_o` is already set drives `rst_req_o` high. If software serviced the timer between two wraps, the second wrap only raises `irq_o` again.
- R6: Writing 1 to bit 0 of the service register (0x0C) clears `irq_o` and the elapsed count at the edge that captures the write. If a wrap falls on the same edge, the service wins. Writing 0 to the service register has no effect. Service bit 0 reads back the interrupt state.
- R7: A write to the period register that is applied while the timer is enabled is ignored.
- R8: Writing 1 to bit 0 of the parity trigger register (0x14) drives `rst_req_o` high when parity-mode bit 0 is 0. When parity-mode bit 0 is 1, the same write has no effect.
- R9: Writes to any register other than the service register take effect `SYNC_TICKS` ticks after capture. Until then, reads return the old value. Service writes act at once.
- R10: The elapsed count holds its value on cycles where `tick_i` is low.
- R11: `rst_req_o` stays high until `rst_ni` is asserted, and a service write does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counting-clock tick enable |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write strobe (0 means read) |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when there is no read |
| irq_o | output | 1 | Interrupt level, set on the first unserviced expiry |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
A wrong compare limit or a prescale shift error moves the interrupt edge away from cycle `4 + (N+1)*2^PRESCALE_W` after the enable write. The bench checks that edge inside a window of a few cycles and for two different periods. A lost or wrongly kept interrupt flag shows up one full period later: either the reset request rises after a service, or it never rises without one. Faults in the staging slot show within a few cycles after a write: a read returns the new value too early, or never returns it. Faults in the lock or sticky logic show in the readback of the period and control registers, and in a reset request that falls after a service.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int PERIOD_W  = 12;
  localparam int PERIOD_LO = DATA_W - PERIOD_W;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t OFF_CTRL    = 5'h00;
  localparam reg_addr_t OFF_PERIOD  = 5'h04;
  localparam reg_addr_t OFF_ELAPSED = 5'h08;
  localparam reg_addr_t OFF_SERVICE = 5'h0C;
  localparam reg_addr_t OFF_PMODE   = 5'h10;
  localparam reg_addr_t OFF_PTRIG   = 5'h14;
endpackage

// File: rtl/wdog_stage.sv
// Staging slot modelling the crossing into the counting domain.
module wdog_stage
  import wdog_pkg::*;
#(
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  reg_addr_t         addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              apply_o,
  output reg_addr_t         apply_addr_o,
  output logic [DATA_W-1:0] apply_data_o
);
  localparam int SC_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

  logic            pend_q;
  logic [SC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      cnt_q        <= '0;
      apply_o      <= 1'b0;
      apply_addr_o <= '0;
      apply_data_o <= '0;
    end else begin
      apply_o <= 1'b0;
      if (wr_i) begin
        pend_q       <= 1'b1;
        cnt_q        <= '0;
        apply_addr_o <= addr_i;
        apply_data_o <= data_i;
      end else if (pend_q && tick_i) begin
        if (cnt_q == SC_W'(SYNC_TICKS - 1)) begin
          apply_o <= 1'b1;
          pend_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + SC_W'(1);
        end
      end
    end
  end

  assert_apply_from_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(apply_o) |-> $past(pend_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int PRESCALE_W = 20,
  localparam int CNT_W = PERIOD_W + PRESCALE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                clear_i,
  input  logic                zero_i,
  input  logic                force_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                irq_o,
  output logic                rst_req_o
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign span  = ((CNT_W+1)'(period_i) + (CNT_W+1)'(1)) << PRESCALE_W;
  assign last  = CNT_W'(span - (CNT_W+1)'(1));
  assign wrap  = en_i && tick_i && (cnt_o == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      if (clear_i || zero_i)   cnt_o <= '0;
      else if (en_i && tick_i) cnt_o <= wrap ? '0 : cnt_o + CNT_W'(1);

      if (clear_i)   irq_o <= 1'b0;
      else if (wrap) irq_o <= 1'b1;

      // second unserviced wrap, or forced parity error
      if (force_i || (wrap && irq_o && !clear_i)) rst_req_o <= 1'b1;
    end
  end

  assert_rst_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  assert_service_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!irq_o && cnt_o == '0));
  assert_cnt_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i && !zero_i) |=> $stable(cnt_o));
  assert_rst_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> ($past(force_i) || $past(irq_o)));
  assert_irq_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_i && tick_i));
endmodule

// File: rtl/wdog_dual_expiry.sv
module wdog_dual_expiry
  import wdog_pkg::*;
#(
  parameter int PRESCALE_W = 20,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = PERIOD_W + PRESCALE_W;

  logic                wr_any, wr_sync, service;
  logic                apply;
  reg_addr_t           apply_addr;
  logic [DATA_W-1:0]   apply_data;
  logic                en_q, pmode_q;
  logic [PERIOD_W-1:0] period_q;
  logic                zero_cnt, force_rst;
  logic [CNT_W-1:0]    cnt;
  logic                unused_bits;

  assign wr_any  = req_i && we_i;
  assign wr_sync = wr_any && (addr_i != OFF_SERVICE);
  assign service = wr_any && (addr_i == OFF_SERVICE) && wdata_i[0];

  wdog_stage #(.SYNC_TICKS(SYNC_TICKS)) u_stage (
    .clk_i, .rst_ni, .tick_i,
    .wr_i(wr_sync), .addr_i, .data_i(wdata_i),
    .apply_o(apply), .apply_addr_o(apply_addr), .apply_data_o(apply_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      period_q <= '0;
      pmode_q  <= 1'b0;
    end else if (apply) begin
      unique case (apply_addr)
        OFF_CTRL:   if (apply_data[0]) en_q <= 1'b1;
        OFF_PERIOD: if (!en_q) period_q <= apply_data[DATA_W-1:PERIOD_LO];
        OFF_PMODE:  pmode_q <= apply_data[0];
        default: ;
      endcase
    end
  end

  assign zero_cnt    = apply && (apply_addr == OFF_ELAPSED);
  assign force_rst   = apply && (apply_addr == OFF_PTRIG) && apply_data[0] && !pmode_q;
  assign unused_bits = ^apply_data[PERIOD_LO-1:1];

  wdog_counter #(.PRESCALE_W(PRESCALE_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .en_i(en_q), .period_i(period_q),
    .clear_i(service), .zero_i(zero_cnt), .force_i(force_rst),
    .cnt_o(cnt), .irq_o, .rst_req_o
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_CTRL:    rdata_o[0] = en_q;
        OFF_PERIOD:  rdata_o[DATA_W-1:PERIOD_LO] = period_q;
        OFF_ELAPSED: rdata_o = DATA_W'(cnt);
        OFF_SERVICE: rdata_o[0] = irq_o;
        OFF_PMODE:   rdata_o[0] = pmode_q;
        default:     rdata_o = '0;
      endcase
    end
  end

  assert_en_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  assert_period_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(period_q));
  assert_reg_change_needs_apply_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> ($stable(en_q) && $stable(period_q) && $stable(pmode_q)));
endmodule

// File: tb/sim_wdog_dual_expiry.sv
module sim_wdog_dual_expiry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int fails  = 0;

  wdog_dual_expiry #(.PRESCALE_W(2), .SYNC_TICKS(3)) u0 (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 1'b1;
    wait_n(2);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    chk(!irq_o && !rst_req_o, "R1 outputs", {30'd0, irq_o, rst_req_o}, 32'd0);
    rd(5'h00, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(5'h04, v); chk(v == 0, "R1 period", v, 0);
    rd(5'h08, v); chk(v == 0, "R1 elapsed", v, 0);
    rd(5'h18, v); chk(v == 0, "R1 unmapped", v, 0);
  endtask

  task automatic t_period_mask_sync();
    logic [31:0] v;
    do_reset();
    wr(5'h04, 32'h005F_FFFF);
    rd(5'h04, v); chk(v == 0, "R9 early read", v, 0);
    wait_n(8);
    rd(5'h04, v); chk(v == 32'h0050_0000, "R9 applied", v, 32'h0050_0000);
    wr(5'h04, 32'hFFFF_FFFF); wait_n(8);
    rd(5'h04, v); chk(v == 32'hFFF0_0000, "R3 field mask", v, 32'hFFF0_0000);
  endtask

  // N=3, prescale 4: period 16 ticks; enable lands 4 cycles after capture
  task automatic t_two_overflows();
    do_reset();
    wr(5'h04, 32'h0030_0000); wait_n(8);
    wr(5'h00, 32'h1);
    wait_n(12); chk(!irq_o, "R4 irq early", irq_o, 0);
    wait_n(12); chk(irq_o, "R4 first expiry", irq_o, 1);
    chk(!rst_req_o, "R5 no reset on first", rst_req_o, 0);
    wait_n(8);  chk(!rst_req_o, "R5 reset early", rst_req_o, 0);
    wait_n(8);  chk(rst_req_o, "R5 second expiry", rst_req_o, 1);
    wr(5'h0C, 32'h1); wait_n(2);
    chk(rst_req_o, "R11 sticky after service", rst_req_o, 1);
    do_reset();
    chk(!rst_req_o, "R11 cleared by rst_ni", rst_req_o, 0);
  endtask

  task automatic t_service();
    logic [31:0] v;
    do_reset();
    wr(5'h04, 32'h0030_0000); wait_n(8);
    wr(5'h00, 32'h1);
    wait_n(24); chk(irq_o, "R6 irq before service", irq_o, 1);
    rd(5'h0C, v); chk(v == 1, "R6 irq readback", v, 1);
    wr(5'h0C, 32'h0);
    chk(irq_o, "R6 zero write ignored", irq_o, 1);
    wr(5'h0C, 32'h1);
    chk(!irq_o, "R6 irq cleared", irq_o, 0);
    rd(5'h08, v); chk(v <= 2, "R6 count cleared", v, 2);
    wait_n(8);
    chk(!irq_o && !rst_req_o, "R5 quiet after service", {30'd0, irq_o, rst_req_o}, 0);
    wait_n(12);
    chk(irq_o, "R5 re-raise irq", irq_o, 1);
    chk(!rst_req_o, "R5 serviced no reset", rst_req_o, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(5'h04, 32'h0030_0000); wait_n(8);
    wr(5'h00, 32'h1); wait_n(8);
    wr(5'h04, 32'hABC0_0000); wait_n(8);
    rd(5'h04, v); chk(v == 32'h0030_0000, "R7 period locked", v, 32'h0030_0000);
    wr(5'h00, 32'h0); wait_n(8);
    rd(5'h00, v); chk(v == 1, "R2 enable sticky", v, 1);
  endtask

  task automatic t_tick_gate();
    logic [31:0] a, b;
    do_reset();
    wr(5'h04, 32'h0FF0_0000); wait_n(8);
    wr(5'h00, 32'h1); wait_n(10);
    @(negedge clk_i); tick_i = 1'b0;
    rd(5'h08, a); wait_n(20); rd(5'h08, b);
    chk(a == b, "R10 frozen count", b, a);
    chk(a != 0, "R2 counter ran", a, 1);
    @(negedge clk_i); tick_i = 1'b1;
    wait_n(3); rd(5'h08, b);
    chk(b > a, "R10 resumes", b, a + 1);
    wr(5'h08, 32'h0); wait_n(2);
    chk(!rst_req_o, "R9 elapsed write pending", rst_req_o, 0);
  endtask

  task automatic t_parity();
    do_reset();
    wr(5'h10, 32'h1); wait_n(8);
    wr(5'h14, 32'h1); wait_n(8);
    chk(!rst_req_o, "R8 masked by mode", rst_req_o, 0);
    wr(5'h10, 32'h0); wait_n(8);
    wr(5'h14, 32'h1);
    wait_n(1); chk(!rst_req_o, "R9 trigger latency", rst_req_o, 0);
    wait_n(7); chk(rst_req_o, "R8 forced reset", rst_req_o, 1);
  endtask

  // N=0: period 4 ticks
  task automatic t_short_period();
    do_reset();
    wr(5'h00, 32'h1);
    wait_n(7); chk(!irq_o, "R4 N0 irq early", irq_o, 0);
    wait_n(2); chk(irq_o, "R4 N0 irq", irq_o, 1);
    chk(!rst_req_o, "R5 N0 reset early", rst_req_o, 0);
    wait_n(4); chk(rst_req_o, "R5 N0 reset", rst_req_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_period_mask_sync();
    t_two_overflows();
    t_service();
    t_lock();
    t_tick_gate();
    t_parity();
    t_short_period();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule